// File: doc/BRIEF.md
# Two-Channel PWM Generator with Event Status and Interrupt

This block drives two independent pulse-width-modulated outputs. Each channel owns a free-running counter, a period value and a duty value. A single global enable bit either runs both channels or parks them with their outputs low. The register side is a plain strobe interface. One shared write-data bus carries the value, and a separate strobe selects which register takes it: global enable, per-channel duty, per-channel period, interrupt mask, or the write-one-to-clear of the interrupt status.

Each time a channel reaches the end of its period, it raises an event. The event sets a bit in a status word that clears when software reads it. It also sets a bit in an interrupt status word that software clears by writing ones. The interrupt line is the OR of the interrupt status bits that the mask enables. Duty and period writes are held in a shadow copy until the end of the current period, so a running output never shows a partial pulse.

Top module: `pwm2_irq_ctrl`

## Requirements
- R1: Each channel counter steps from 0 up to its period value inclusive, then returns to 0. The output is high while counter < duty, so a duty of 0 gives a constantly low output and a duty above the period gives a constantly high output. Over one period of P+1 cycles, the output is high for min(duty, P+1) cycles.
- R2: After reset, both channels have duty 128 and period 255, global enable is 0, the mask is 0, both status words are 0, and all outputs are low.
- R3: A global-enable write strobe loads bit 0 of the write data. While that bit is 0, both counters hold at 0, both outputs are low, and no period events occur.
- R4: Duty and period writes made while a channel runs take effect only at that channel's next period end. Writes made while disabled take effect before the first enabled cycle.
- R5: Status bit n (bit 0 = channel 0, bit 1 = channel 1) sets on each period end of channel n and stays set until a status read strobe. The read strobe clears the whole word in the cycle after the read.
- R6: A period end in the same cycle as a status read leaves that bit set.
- R7: Interrupt status bit n sets on each period end of channel n. A clear strobe clears only the bits whose write-data bit is 1; bits written 0 are unchanged.
- R8: The interrupt mask loads write-data bits [1:0] on its strobe. The interrupt line is high when any interrupt status bit is set whose mask bit is also set.
- R9: A period end in the same cycle as a clear strobe for that bit leaves the interrupt status bit set.
- R10: The two channels run independently, each with its own duty and period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wdata | input | WDATA_W (32) | Shared register write data |
| glb_en_wr | input | 1 | Global enable write strobe (bit 0 of wdata) |
| duty_wr | input | NCH (2) | Per-channel duty write strobe |
| period_wr | input | NCH (2) | Per-channel period write strobe |
| irq_en_wr | input | 1 | Interrupt mask write strobe |
| irq_clr_wr | input | 1 | Interrupt status write-one-to-clear strobe |
| sts_rd | input | 1 | Status word read strobe (clears on read) |
| pwm_out | output | NCH (2) | PWM outputs |
| sts_word | output | NCH (2) | Clear-on-read status word |
| irq_sts | output | NCH (2) | Interrupt status word |
| irq_en | output | NCH (2) | Interrupt mask |
| irq | output | 1 | Interrupt line |

## Verification
The hardest situation to reach from the ports is a period end that lands in the same cycle as a status read or an interrupt clear, because the bench cannot normally predict the exact wrap cycle. The stimulus forces this case by giving one channel a period of 0. That channel then ends a period in every enabled cycle, so any read or clear strobe is sure to collide with a set. The shadow-register behaviour is reached by writing a new duty value part way through a running period. The bench then counts high cycles over that period and over the next one.

// File: rtl/pwm2_pkg.sv
// Package: pwm2_pkg
// Shared constants for the two-channel PWM block: counter width and the
// per-channel reset values for duty and period.
package pwm2_pkg;
    localparam int CNT_W_DEF      = 8;
    localparam int DUTY_RST_DEF   = 128;
    localparam int PERIOD_RST_DEF = 255;
    localparam int WDATA_W_DEF    = 32;

    // Next value of a sticky event word: clear selected bits, then set new events.
    function automatic logic [1:0] sticky_next(input logic [1:0] cur,
                                               input logic [1:0] clr,
                                               input logic [1:0] set);
        return (cur & ~clr) | set;
    endfunction
endpackage

// File: rtl/pwm2_chan.sv
// Module: pwm2_chan
// One PWM channel. The counter runs from 0 to the active period inclusive.
// The output is high while count < active duty. Written duty and period values
// sit in a shadow copy and move to the active copy at a period end, or in
// every cycle while the channel is disabled.
// Assumes: en is a registered level; the write strobes last one cycle each.
module pwm2_chan #(
    parameter int CNT_W      = 8,
    parameter int DUTY_RST   = 128,
    parameter int PERIOD_RST = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             duty_wr,
    input  logic             period_wr,
    input  logic [CNT_W-1:0] wdata,
    output logic             pwm,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] DUTY_INIT = CNT_W'(DUTY_RST);
    localparam logic [CNT_W-1:0] PER_INIT  = CNT_W'(PERIOD_RST);

    logic [CNT_W-1:0] shd_duty, shd_per;
    logic [CNT_W-1:0] act_duty, act_per;
    logic [CNT_W-1:0] cnt;

    // Period end: the counter sits on the active period while running.
    assign wrap = en && (cnt == act_per);
    // Output compare against the active duty.
    assign pwm  = en && (cnt < act_duty);

    // Shadow registers take software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_duty <= DUTY_INIT;
            shd_per  <= PER_INIT;
        end else begin
            if (duty_wr)   shd_duty <= wdata;
            if (period_wr) shd_per  <= wdata;
        end
    end

    // Counter and active copy: hold at 0 when disabled, reload at period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            act_duty <= DUTY_INIT;
            act_per  <= PER_INIT;
        end else if (!en || wrap) begin
            cnt      <= '0;
            act_duty <= shd_duty;
            act_per  <= shd_per;
        end else begin
            cnt      <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pwm2_evt.sv
// Module: pwm2_evt
// Event words for the PWM channels: a clear-on-read status word, and a
// write-one-to-clear interrupt status word qualified by a mask. A new event
// in the same cycle as a clear always wins.
// Assumes: wrap bits last one cycle per period end.
module pwm2_evt #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] wrap,
    input  logic           sts_rd,
    input  logic           irq_clr_wr,
    input  logic           irq_en_wr,
    input  logic [NCH-1:0] wmask,
    output logic [NCH-1:0] sts,
    output logic [NCH-1:0] irq_sts,
    output logic [NCH-1:0] irq_en,
    output logic           irq
);
    logic [NCH-1:0] rd_clr, w1c_clr;

    // Clear vectors for the two words.
    assign rd_clr  = sts_rd     ? {NCH{1'b1}} : '0;
    assign w1c_clr = irq_clr_wr ? wmask       : '0;

    // Sticky status words; a set has priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts     <= '0;
            irq_sts <= '0;
        end else begin
            sts     <= (sts & ~rd_clr) | wrap;
            irq_sts <= (irq_sts & ~w1c_clr) | wrap;
        end
    end

    // Interrupt mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)         irq_en <= '0;
        else if (irq_en_wr) irq_en <= wmask;
    end

    // Interrupt line: any enabled pending bit.
    assign irq = |(irq_sts & irq_en);
endmodule

// File: rtl/pwm2_irq_ctrl.sv
// Module: pwm2_irq_ctrl
// Top level of the two-channel PWM generator. It holds the global enable bit,
// the PWM channels and the event/interrupt words behind a strobe-per-register
// write interface with shared write data.
// Assumes: all strobes are synchronous to clk and last one cycle.
module pwm2_irq_ctrl #(
    parameter int NCH        = 2,
    parameter int CNT_W      = pwm2_pkg::CNT_W_DEF,
    parameter int WDATA_W    = pwm2_pkg::WDATA_W_DEF,
    parameter int DUTY_RST   = pwm2_pkg::DUTY_RST_DEF,
    parameter int PERIOD_RST = pwm2_pkg::PERIOD_RST_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WDATA_W-1:0] wdata,
    input  logic               glb_en_wr,
    input  logic [NCH-1:0]     duty_wr,
    input  logic [NCH-1:0]     period_wr,
    input  logic               irq_en_wr,
    input  logic               irq_clr_wr,
    input  logic               sts_rd,
    output logic [NCH-1:0]     pwm_out,
    output logic [NCH-1:0]     sts_word,
    output logic [NCH-1:0]     irq_sts,
    output logic [NCH-1:0]     irq_en,
    output logic               irq
);
    logic           en_q;
    logic [NCH-1:0] wrap;

    // Global enable register, bit 0 of the write data.
    always_ff @(posedge clk) begin
        if (!rst_n)         en_q <= 1'b0;
        else if (glb_en_wr) en_q <= wdata[0];
    end

    // One PWM channel per output.
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm2_chan #(
            .CNT_W(CNT_W), .DUTY_RST(DUTY_RST), .PERIOD_RST(PERIOD_RST)
        ) u_chan (
            .clk(clk), .rst_n(rst_n), .en(en_q),
            .duty_wr(duty_wr[g]), .period_wr(period_wr[g]),
            .wdata(wdata[CNT_W-1:0]),
            .pwm(pwm_out[g]), .wrap(wrap[g])
        );
    end

    pwm2_evt #(.NCH(NCH)) u_evt (
        .clk(clk), .rst_n(rst_n), .wrap(wrap),
        .sts_rd(sts_rd), .irq_clr_wr(irq_clr_wr), .irq_en_wr(irq_en_wr),
        .wmask(wdata[NCH-1:0]),
        .sts(sts_word), .irq_sts(irq_sts), .irq_en(irq_en), .irq(irq)
    );

    // Upper write-data bits that no register uses.
    if (WDATA_W > CNT_W) begin : g_hi
        logic unused_hi;
        assign unused_hi = ^wdata[WDATA_W-1:CNT_W];
    end
endmodule

// File: rtl/pwm2_irq_chk.sv
// Module: pwm2_irq_chk
// Temporal checks on the PWM block, bound to every instance of the top.
module pwm2_irq_chk #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           en_q,
    input logic [NCH-1:0] wrap,
    input logic           sts_rd,
    input logic           irq_clr_wr,
    input logic           irq_en_wr,
    input logic [NCH-1:0] wmask,
    input logic [NCH-1:0] pwm,
    input logic [NCH-1:0] sts,
    input logic [NCH-1:0] irq_sts,
    input logic           irq
);
    // R3: disabled channels produce no output and no new status.
    a_r3_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> pwm == '0);
    a_r3_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !sts_rd) |=> $stable(sts));
    // R8: a cleared mask silences the interrupt line.
    a_r8_masked_off: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en_wr && wmask == '0) |=> !irq);

    for (genvar n = 0; n < NCH; n++) begin : g_bit
        // R5: status is sticky until read, and cleared by a read.
        a_r5_sts_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (sts[n] && !sts_rd) |=> sts[n]);
        a_r5_sts_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_rd && !wrap[n]) |=> !sts[n]);
        // R6 and R9: a period end always lands in both words.
        a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            wrap[n] |=> (sts[n] && irq_sts[n]));
        // R7: interrupt status holds unless cleared by a one.
        a_r7_w1c_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_sts[n] && !(irq_clr_wr && wmask[n])) |=> irq_sts[n]);
    end
endmodule

bind pwm2_irq_ctrl pwm2_irq_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .wrap(wrap),
    .sts_rd(sts_rd), .irq_clr_wr(irq_clr_wr), .irq_en_wr(irq_en_wr),
    .wmask(wdata[NCH-1:0]), .pwm(pwm_out), .sts(sts_word),
    .irq_sts(irq_sts), .irq(irq)
);

// File: tb/tb_pwm2_irq_ctrl.sv
module tb_pwm2_irq_ctrl;
    localparam int NCH = 2;
    localparam int WW  = 32;
    // Vectors: duty0, period0, duty1, period1
    localparam int NV = 4;
    localparam int VEC [NV][4] = '{
        '{3, 7, 5, 4},
        '{0, 5, 9, 9},
        '{6, 5, 1, 0},
        '{2, 2, 0, 3}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [WW-1:0]  wdata = '0;
    logic           glb_en_wr = 1'b0, irq_en_wr = 1'b0, irq_clr_wr = 1'b0, sts_rd = 1'b0;
    logic [NCH-1:0] duty_wr = '0, period_wr = '0;
    logic [NCH-1:0] pwm_out, sts_word, irq_sts, irq_en;
    logic           irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    pwm2_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wdata(wdata), .glb_en_wr(glb_en_wr),
        .duty_wr(duty_wr), .period_wr(period_wr), .irq_en_wr(irq_en_wr),
        .irq_clr_wr(irq_clr_wr), .sts_rd(sts_rd), .pwm_out(pwm_out),
        .sts_word(sts_word), .irq_sts(irq_sts), .irq_en(irq_en), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Register write strobes: 0 enable, 1 duty, 2 period, 3 mask, 4 w1c.
    task automatic wr(input int kind, input int ch, input int val);
        @(negedge clk);
        wdata = WW'(val);
        case (kind)
            0: glb_en_wr = 1'b1;
            1: duty_wr[ch] = 1'b1;
            2: period_wr[ch] = 1'b1;
            3: irq_en_wr = 1'b1;
            default: irq_clr_wr = 1'b1;
        endcase
        @(negedge clk);
        glb_en_wr = 1'b0; duty_wr = '0; period_wr = '0;
        irq_en_wr = 1'b0; irq_clr_wr = 1'b0; wdata = '0;
    endtask

    task automatic rd_sts();
        @(negedge clk); sts_rd = 1'b1;
        @(negedge clk); sts_rd = 1'b0;
    endtask

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    // Watchdog: counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int h0, h1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        chk("R2 pwm_out", pwm_out, 0);
        chk("R2 irq", irq, 0);
        chk("R2 sts_word", sts_word, 0);
        chk("R2 irq_sts", irq_sts, 0);
        // R3: disabled after reset, nothing happens
        repeat (300) @(negedge clk);
        chk("R3 idle sts", sts_word, 0);
        chk("R3 idle pwm", pwm_out, 0);

        // R2: default duty 128 period 255 on both channels
        wr(0, 0, 1);
        h0 = 0; h1 = 0;
        for (int i = 0; i < 256; i++) begin
            h0 += pwm_out[0]; h1 += pwm_out[1];
            @(negedge clk);
        end
        chk("R2 default ch0 highs", h0, 128);
        chk("R2 default ch1 highs", h1, 128);
        chk("R5 sts after default period", sts_word, 3);

        // R1 R10: vector table
        for (int v = 0; v < NV; v++) begin
            int mx;
            wr(0, 0, 0);
            wr(1, 0, VEC[v][0]); wr(2, 0, VEC[v][1]);
            wr(1, 1, VEC[v][2]); wr(2, 1, VEC[v][3]);
            rd_sts();
            wr(4, 0, 3);
            wr(0, 0, 1);
            mx = (VEC[v][1] > VEC[v][3]) ? VEC[v][1] : VEC[v][3];
            h0 = 0; h1 = 0;
            for (int i = 0; i <= mx; i++) begin
                if (i <= VEC[v][1]) h0 += pwm_out[0];
                if (i <= VEC[v][3]) h1 += pwm_out[1];
                @(negedge clk);
            end
            chk("R1 ch0 highs", h0, imin(VEC[v][0], VEC[v][1] + 1));
            chk("R10 ch1 highs", h1, imin(VEC[v][2], VEC[v][3] + 1));
            chk("R5 sts after period", sts_word, 3);
        end

        // R4: duty written mid-period waits for the period end
        wr(0, 0, 0);
        wr(1, 0, 3); wr(2, 0, 7);
        wr(1, 1, 1); wr(2, 1, 200);
        rd_sts();
        wr(4, 0, 3);
        wr(3, 0, 0);
        wr(0, 0, 1);
        h0 = 0;
        for (int i = 0; i < 8; i++) begin
            h0 += pwm_out[0];
            if (i == 1) begin duty_wr[0] = 1'b1; wdata = 6; end
            if (i == 2) begin duty_wr[0] = 1'b0; wdata = 0; end
            @(negedge clk);
        end
        chk("R4 current period keeps old duty", h0, 3);
        h0 = 0;
        for (int i = 0; i < 8; i++) begin
            h0 += pwm_out[0];
            @(negedge clk);
        end
        chk("R4 next period uses new duty", h0, 6);
        wr(0, 0, 0);

        // R7 R8: mask and write-one-to-clear (channels parked)
        chk("R7 irq_sts ch0 only", irq_sts, 1);
        chk("R8 irq masked", irq, 0);
        wr(3, 0, 2);
        chk("R8 mask other bit", irq, 0);
        wr(3, 0, 1);
        chk("R8 mask matching bit", irq, 1);
        wr(4, 0, 2);
        chk("R7 zero bit no effect", irq_sts, 1);
        wr(4, 0, 1);
        chk("R7 one bit clears", irq_sts, 0);
        chk("R8 irq drops", irq, 0);

        // R6 R9: period 0 wraps every cycle, colliding with every clear
        wr(1, 0, 1); wr(2, 0, 200);
        wr(1, 1, 0); wr(2, 1, 0);
        rd_sts();
        wr(4, 0, 3);
        wr(0, 0, 1);
        repeat (3) @(negedge clk);
        rd_sts();
        chk("R6 read during wrap keeps bit", sts_word, 2);
        wr(4, 0, 2);
        chk("R9 clear during wrap keeps bit", irq_sts, 2);
        wr(0, 0, 0);
        rd_sts();
        chk("R5 read clears when idle", sts_word, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule